// File: doc/BRIEF.md
# Receive Bit Tally with Saturation

This block keeps a running tally of received data bits on the receive side of a bit-error-rate tester. Every cycle in which the receive bit enable is high stands for one received bit. The tally stays idle after reset until the receiver first reports synchronization. From then on it keeps counting, even if synchronization is lost again. The tally never wraps. When it reaches its all-ones value it stops there and raises a sticky overflow flag.

Software clears the tally and the flag by raising a clear-control level from low to high. A typical measurement clears once synchronization is reached, waits out the test window, and then reads the total. The count is read through a registered 16-bit read port. Reading the low word also latches the high word into a holding register, so a low-then-high read pair always returns halves of the same value. A third address returns the overflow flag. The full count is also available as a parallel output.

Top module: `bert_bit_tally`

## Requirements
- R1: Once counting is enabled, each cycle with `bit_en` high raises `count` by exactly one at the next clock edge. A cycle with `bit_en` low leaves it unchanged. The width is `CNT_W`, 32 by default.
- R2: After reset, `bit_en` has no effect on `count` until `rx_in_sync` has been seen high.
- R3: A `bit_en` pulse in the very cycle `rx_in_sync` is first high is counted. Counting then continues whatever `rx_in_sync` does, until the next reset.
- R4: When `count` is all ones, further `bit_en` pulses leave it at all ones. It never wraps to zero.
- R5: `ovf_flag` rises at the same clock edge at which `count` becomes all ones. It stays high until a clear event or reset, whether or not counting goes on.
- R6: A clear event is a cycle in which `clr_ctl` is high after being low in the previous cycle. At that edge it sets `count` to zero and `ovf_flag` low, even if `bit_en` is also high. Keeping `clr_ctl` high or lowering it has no effect.
- R7: A clear event does not disarm counting. After a clear taken while `rx_in_sync` is low, `bit_en` pulses are counted at once.
- R8: One edge after a cycle with `rd_en` high, `rd_data` holds the selected word:
  - address 0x78 returns `count[15:0]` and, at the same edge, latches `count[31:16]` into a holding register;
  - address 0x7A returns the holding register;
  - address 0x7C returns the overflow flag in bit 0, with all other bits zero;
  - any other address returns zero.

  While `rd_en` is low, `rd_data` keeps its value.
- R9: Reset (`rst_n` low) clears `count`, `ovf_flag`, `rd_data`, the holding register and the armed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One received data bit in this cycle |
| rx_in_sync | input | 1 | Receiver reports pattern synchronization |
| clr_ctl | input | 1 | Host clear-control level; a rising edge clears |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W (8) | Host read address |
| rd_data | output | WORD_W (16) | Registered read data |
| count | output | CNT_W (32) | Current bit tally |
| ovf_flag | output | 1 | Sticky saturation status |

## Verification
`count` and `ovf_flag` change at the first rising edge that samples `bit_en`, `rx_in_sync` or `clr_ctl`, so both are due one edge after their stimulus. `rd_data` is likewise due one edge after the `rd_en` cycle. The holding register fills at that same edge, so the matching high-word read returns the value captured then.

The bench changes inputs just after each falling edge. A behavioural model advances on every rising edge. Every output of both instances is compared with the model at the following falling edge, which is exactly one edge after the stimulus. Spot checks are taken two time units after a rising edge that follows an idle cycle, so the value they see has settled.

A second instance with a 17-bit count reaches saturation within the run. It also makes the holding register carry a non-zero high word.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

   // which word the read port returns
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_STAT = 2'd3
   } rd_sel_e;

   localparam int unsigned BBT_WORD_W = 16;
   localparam int unsigned BBT_ADDR_W = 8;

endpackage

// File: rtl/bbt_clr_edge.sv
module bbt_clr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_lvl,
   output logic clr_pulse
);

   logic clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_q <= 1'b0;
      else        clr_q <= clr_lvl;
   end

   assign clr_pulse = clr_lvl & ~clr_q;

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !clr_pulse);

endmodule

// File: rtl/bbt_arm.sv
module bbt_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic armed,
   output logic count_ok
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (sync_in) armed_q <= 1'b1;
   end

   assign armed    = armed_q;
   assign count_ok = armed_q | sync_in;

   // R3
   armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q);

endmodule

// File: rtl/bbt_sat_count.sv
module bbt_sat_count #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_req,
   input  logic         clr_evt,
   output logic [W-1:0] cnt,
   output logic         ovf
);

   localparam logic [W-1:0] ALL1 = {W{1'b1}};
   localparam logic [W-1:0] PRE1 = ALL1 - W'(1);

   logic [W-1:0] cnt_q;
   logic         ovf_q;
   logic         at_max;
   logic         step;
   logic         reach;

   assign at_max = (cnt_q == ALL1);
   assign step   = inc_req & ~at_max;
   assign reach  = step & (cnt_q == PRE1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_evt) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (step)  cnt_q <= cnt_q + W'(1);
         if (reach) ovf_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;

   // R1
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_req && !clr_evt && cnt_q != ALL1) |=> cnt_q == $past(cnt_q) + W'(1));
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_req && !clr_evt) |=> $stable(cnt_q));
   // R4
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == ALL1 && !clr_evt) |=> cnt_q == ALL1);
   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_evt) |=> ovf_q);
   // R5
   ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> cnt_q == ALL1);
   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> (cnt_q == '0 && !ovf_q));

endmodule

// File: rtl/bbt_rd_port.sv
module bbt_rd_port
   import bbt_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned LO_ADDR   = 'h78,
   parameter int unsigned HI_ADDR   = 'h7A,
   parameter int unsigned STAT_ADDR = 'h7C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              ovf,
   output logic [WORD_W-1:0] rd_data
);

   localparam int unsigned HI_W = (CNT_W > WORD_W) ? CNT_W - WORD_W : 1;

   rd_sel_e           sel;
   logic [WORD_W-1:0] lo_word;
   logic [WORD_W-1:0] hi_word;
   logic [WORD_W-1:0] stat_word;
   logic [WORD_W-1:0] next_data;
   logic [WORD_W-1:0] rd_q;

   always_comb begin
      if      (rd_addr == ADDR_W'(LO_ADDR))   sel = SEL_LO;
      else if (rd_addr == ADDR_W'(HI_ADDR))   sel = SEL_HI;
      else if (rd_addr == ADDR_W'(STAT_ADDR)) sel = SEL_STAT;
      else                                    sel = SEL_NONE;
   end

   generate
      if (CNT_W > WORD_W) begin : g_split
         logic [HI_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      hold_q <= '0;
            else if (rd_en && sel == SEL_LO) hold_q <= cnt[CNT_W-1:WORD_W];
         end
         assign lo_word = cnt[WORD_W-1:0];
         assign hi_word = WORD_W'(hold_q);
      end else begin : g_narrow
         assign lo_word = WORD_W'(cnt);
         assign hi_word = '0;
      end
   endgenerate

   assign stat_word = WORD_W'(ovf);

   always_comb begin
      unique case (sel)
         SEL_LO:   next_data = lo_word;
         SEL_HI:   next_data = hi_word;
         SEL_STAT: next_data = stat_word;
         default:  next_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= next_data;
   end

   assign rd_data = rd_q;

   // R8
   rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   // R8
   rd_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(STAT_ADDR)) |=> rd_data == WORD_W'($past(ovf)));
   // R8
   rd_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(LO_ADDR)) |=> rd_data == $past(lo_word));

endmodule

// File: rtl/bert_bit_tally.sv
module bert_bit_tally
   import bbt_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned WORD_W    = BBT_WORD_W,
   parameter int unsigned ADDR_W    = BBT_ADDR_W,
   parameter int unsigned LO_ADDR   = 'h78,
   parameter int unsigned HI_ADDR   = 'h7A,
   parameter int unsigned STAT_ADDR = 'h7C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_in_sync,
   input  logic              clr_ctl,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag
);

   initial begin
      assert (CNT_W >= 2)
         else $error("CNT_W must be at least 2");
      assert (CNT_W <= 2 * WORD_W)
         else $error("CNT_W must fit in two read words");
      assert (LO_ADDR != HI_ADDR && LO_ADDR != STAT_ADDR && HI_ADDR != STAT_ADDR)
         else $error("read addresses must differ");
      assert (STAT_ADDR < (1 << ADDR_W) && LO_ADDR < (1 << ADDR_W) && HI_ADDR < (1 << ADDR_W))
         else $error("read address exceeds ADDR_W");
   end

   logic clr_evt;
   logic armed;
   logic count_ok;
   logic inc_req;

   bbt_clr_edge u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_lvl   (clr_ctl),
      .clr_pulse (clr_evt)
   );

   bbt_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (rx_in_sync),
      .armed    (armed),
      .count_ok (count_ok)
   );

   assign inc_req = bit_en & count_ok;

   bbt_sat_count #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_req (inc_req),
      .clr_evt (clr_evt),
      .cnt     (count),
      .ovf     (ovf_flag)
   );

   bbt_rd_port #(
      .CNT_W     (CNT_W),
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .LO_ADDR   (LO_ADDR),
      .HI_ADDR   (HI_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .cnt     (count),
      .ovf     (ovf_flag),
      .rd_data (rd_data)
   );

   // R2
   count_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |-> armed);

endmodule

// File: tb/bert_bit_tally_tb.sv
module bert_bit_tally_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        rx_in_sync = 1'b0;
   logic        clr_ctl = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = 8'h00;
   logic [15:0] rd0, rd1;
   logic [31:0] cnt0;
   logic [16:0] cnt1;
   logic        ovf0, ovf1;

   int n_chk = 0;
   int n_fail = 0;

   longint m_cnt[2], m_hold[2], m_rd[2], mx[2];
   bit     m_ovf[2], m_arm[2];
   bit     m_clrp;

   always #5 clk = ~clk;

   bert_bit_tally u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_in_sync(rx_in_sync),
      .clr_ctl(clr_ctl), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd0), .count(cnt0), .ovf_flag(ovf0)
   );

   bert_bit_tally #(.CNT_W(17)) u_dut_sat (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_in_sync(rx_in_sync),
      .clr_ctl(clr_ctl), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd1), .count(cnt1), .ovf_flag(ovf1)
   );

   task automatic cmp(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   initial begin
      mx[0] = 64'hFFFF_FFFF;
      mx[1] = (64'd1 << 17) - 1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_hold[k] = 0; m_rd[k] = 0; m_ovf[k] = 0; m_arm[k] = 0;
         end
         m_clrp = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            if (rd_en) begin
               case (rd_addr)
                  8'h78: begin m_rd[k] = m_cnt[k] % 65536; m_hold[k] = m_cnt[k] / 65536; end
                  8'h7A: m_rd[k] = m_hold[k];
                  8'h7C: m_rd[k] = m_ovf[k];
                  default: m_rd[k] = 0;
               endcase
            end
            if (clr_ctl && !m_clrp) begin
               m_cnt[k] = 0; m_ovf[k] = 0;
            end else if (bit_en && (m_arm[k] || rx_in_sync) && m_cnt[k] < mx[k]) begin
               m_cnt[k] = m_cnt[k] + 1;
               if (m_cnt[k] == mx[k]) m_ovf[k] = 1;
            end
            if (rx_in_sync) m_arm[k] = 1;
         end
         m_clrp = clr_ctl;
      end
   end

   // every-cycle comparison, one edge after the stimulus
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R1/R4 count u_dut", longint'(cnt0), m_cnt[0]);
         cmp("R1/R4 count u_dut_sat", longint'(cnt1), m_cnt[1]);
         cmp("R5 ovf u_dut", longint'(ovf0), longint'(m_ovf[0]));
         cmp("R5 ovf u_dut_sat", longint'(ovf1), longint'(m_ovf[1]));
         cmp("R8 rd_data u_dut", longint'(rd0), m_rd[0]);
         cmp("R8 rd_data u_dut_sat", longint'(rd1), m_rd[1]);
      end
   end

   task automatic cyc(input bit e, input bit s, input bit c, input bit r, input logic [7:0] a);
      @(negedge clk); #1;
      bit_en = e; rx_in_sync = s; clr_ctl = c; rd_en = r; rd_addr = a;
   endtask

   task automatic settle();
      @(negedge clk); #1;
      bit_en = 1'b0; rd_en = 1'b0;
      @(posedge clk); #2;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      // R9 reset state
      repeat (3) @(posedge clk);
      #2;
      cmp("R9 reset count", longint'(cnt0), 0);
      cmp("R9 reset ovf", longint'(ovf0), 0);
      cmp("R9 reset rd_data", longint'(rd0), 0);
      @(negedge clk); #1; rst_n = 1'b1;

      // R2: no count before first sync
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 8'h00);
      settle();
      cmp("R2 unarmed count", longint'(cnt0), 0);
      cmp("R2 unarmed count sat", longint'(cnt1), 0);

      // R3: pulse in the sync cycle counts, then sync drops
      cyc(1, 1, 0, 0, 8'h00);
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 8'h00);
      settle();
      cmp("R3 R1 count after sync loss", longint'(cnt0), 10);

      // R8 read decode
      cyc(0, 0, 0, 1, 8'h78); settle();
      cmp("R8 low word", longint'(rd0), 10);
      cyc(0, 0, 0, 1, 8'h7A); settle();
      cmp("R8 high word", longint'(rd0), 0);
      cyc(0, 0, 0, 1, 8'h7C); settle();
      cmp("R8 status word", longint'(rd0), 0);
      cyc(0, 0, 0, 1, 8'h78); settle();
      cyc(0, 0, 0, 1, 8'h40); settle();
      cmp("R8 unmapped address", longint'(rd0), 0);
      cyc(0, 0, 0, 1, 8'h78);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 8'h00);
      settle();
      cmp("R8 rd_data held without rd_en", longint'(rd0), 10);
      cmp("R1 count", longint'(cnt0), 13);

      // R6 clear priority and level insensitivity
      cyc(1, 0, 1, 0, 8'h00); settle();
      cmp("R6 clear beats increment", longint'(cnt0), 0);
      for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 8'h00);
      settle();
      cmp("R6 held clear level ignored", longint'(cnt0), 3);
      cyc(1, 0, 0, 0, 8'h00); settle();
      cmp("R6 falling clear ignored", longint'(cnt0), 4);

      // R7 clear out of sync keeps arming
      cyc(0, 0, 1, 0, 8'h00); settle();
      cmp("R7 cleared", longint'(cnt0), 0);
      cyc(1, 0, 1, 0, 8'h00); cyc(1, 0, 1, 0, 8'h00); settle();
      cmp("R7 counts after clear without sync", longint'(cnt0), 2);

      // R4 R5 saturation on the 17-bit instance, with coherent reads
      for (int i = 0; i < 131080; i++)
         cyc(1, 1, 0, (i % 8192 == 0) || (i % 8192 == 5), (i % 8192 == 0) ? 8'h78 : 8'h7A);
      settle();
      cmp("R4 saturated count", longint'(cnt1), 131071);
      cmp("R5 ovf set", longint'(ovf1), 1);
      cmp("R5 no ovf on wide count", longint'(ovf0), 0);
      cmp("R1 wide count", longint'(cnt0), 131082);
      cyc(0, 1, 0, 1, 8'h78); settle();
      cmp("R8 low word saturated", longint'(rd1), 65535);
      cmp("R8 low word wide", longint'(rd0), 10);
      cyc(0, 1, 0, 1, 8'h7A); settle();
      cmp("R8 held high word saturated", longint'(rd1), 1);
      cmp("R8 held high word wide", longint'(rd0), 2);
      cyc(0, 1, 0, 1, 8'h7C); settle();
      cmp("R5 R8 status read", longint'(rd1), 1);

      // R5 sticky, R4 holds, without sync
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 8'h00);
      settle();
      cmp("R4 still saturated", longint'(cnt1), 131071);
      cmp("R5 ovf sticky", longint'(ovf1), 1);
      cmp("R3 counting without sync", longint'(cnt0), 131087);

      // R6 clear after saturation
      cyc(0, 0, 1, 0, 8'h00); settle();
      cmp("R6 clear count sat", longint'(cnt1), 0);
      cmp("R6 clear ovf", longint'(ovf1), 0);
      cmp("R6 clear count wide", longint'(cnt0), 0);

      // R9 reset disarms
      @(negedge clk); #1; rst_n = 1'b0; clr_ctl = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      cmp("R9 reset rd_data", longint'(rd1), 0);
      @(negedge clk); #1; rst_n = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 8'h00);
      settle();
      cmp("R9 R2 disarmed by reset", longint'(cnt0), 0);

      repeat (3) @(posedge clk);
      summary();
      $finish;
   end

endmodule